// File: doc/BRIEF.md
# TDM Audio Receive Slot Engine

This block takes a serial time-division-multiplexed audio stream on a single data pin and turns it into parallel sample words. It runs directly on the receive bit clock. A frame-sync input marks where each frame begins. Inside a frame the engine counts bits into fixed-width slots and keeps track of the slot index. Each completed slot is either handed downstream or discarded, as decided by a 32-bit slot-enable mask. Only TDM framing is understood. A two-channel I2S stream is simply a TDM frame with two slots, where the word-select line acts as the frame sync.

A 2-bit lane-mode input decides whether the lane receives at all. Only the receive code enables it. Any other code holds the framing logic cleared and suppresses output. Captured words leave on a valid/ready port together with their slot index. The serial line cannot be stalled, so back-pressure is absorbed by a single holding register:
- The register keeps its word until the consumer takes it.
- A word that completes while the register is still occupied, and is not being taken in that cycle, is lost.

Top module: `tdm_rx_slot_engine`

## Requirements
- R1: The lane receives only while `lane_mode` equals 2'b10. With codes 2'b00, 2'b01 or 2'b11 no word is ever presented, and framing restarts only at the next frame start after receive mode returns.
- R2: A frame starts on a rising edge of `fsync` as sampled on a rising `bclk` edge. The data bit sampled on that same edge is the MSB of slot 0. A high level that persists over later edges does not restart the frame.
- R3: Data is sampled on rising `bclk`, MSB first. `SLOT_W` consecutive bits form one slot, and slot indices count up from 0 within a frame.
- R4: A completed slot is delivered only if bit (index mod 32) of `slot_mask` is 1. When that bit is 0 the slot is shifted in and then discarded. This applies to indices 32 and above too.
- R5: Frames of up to `MAX_SLOTS` slots (default 384) are accepted. Bits that arrive after slot `MAX_SLOTS-1` produce nothing until the next frame start.
- R6: An I2S stream is handled as a two-slot frame. Word select is high for the whole of slot 0, only its rising edge starts the frame, and the slots arrive as indices 0 and 1.
- R7: A frame start that arrives part-way through a slot abandons that partial slot, and no word is produced for it.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_slot` hold steady. A slot completing in that state is dropped.
- R9: If a word is taken (`out_valid` and `out_ready` both 1) on the same edge that a new active slot completes, the new word is loaded and `out_valid` stays 1.
- R10: After reset `out_valid` is 0. Nothing is produced before the first frame start.
- R11: `out_valid` rises on the same `bclk` edge that samples the last bit of an active slot. `out_data` then carries the slot word and `out_slot` carries its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Receive bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_mode | input | 2 | Lane operating code; 2'b10 selects receive |
| slot_mask | input | 32 | Per-slot enable, bit k covers slots with index mod 32 equal to k |
| fsync | input | 1 | Frame sync / word select; a rising edge starts a frame |
| sdata | input | 1 | Serial audio data |
| out_valid | output | 1 | A captured word is held for the consumer |
| out_ready | input | 1 | Consumer accepts the held word |
| out_data | output | SLOT_W | Captured slot word, first received bit in the MSB |
| out_slot | output | SLOT_IDX_W | Slot index of the held word |

## Verification
Two events can land on the same edge: the completion of an active slot, and the consumer taking the word already held. The bench provokes this by holding `out_ready` low after slot 0 has been captured, then raising it only during the cycle that samples the final bit of slot 1. The check passes only if `out_valid` stays high and the output now shows slot 1's word and index. A second collision is also exercised: a frame start arriving in the middle of a slot, which must discard the partial slot rather than complete it.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  typedef enum logic [1:0] {
    LANE_OFF  = 2'd0,
    LANE_RSV1 = 2'd1,
    LANE_RX   = 2'd2,
    LANE_RSV3 = 2'd3
  } lane_mode_e;

  localparam int MASK_BITS = 32;
endpackage

// File: rtl/tdm_slot_tracker.sv
module tdm_slot_tracker #(
  parameter int SLOT_W     = 32,
  parameter int MAX_SLOTS  = 384,
  parameter int SLOT_IDX_W = $clog2(MAX_SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_en,
  input  logic                  fsync,
  output logic                  frame_start,
  output logic                  slot_done,
  output logic [SLOT_IDX_W-1:0] slot_idx
);
  localparam int BIT_W = (SLOT_W > 2) ? $clog2(SLOT_W) : 1;
  localparam logic [BIT_W-1:0]      LAST_BIT = BIT_W'(SLOT_W - 1);
  localparam logic [SLOT_IDX_W-1:0] SLOT_LIM = SLOT_IDX_W'(MAX_SLOTS);

  logic                  fs_q;
  logic                  locked;
  logic [BIT_W-1:0]      bit_cnt;
  logic [SLOT_IDX_W-1:0] slot_q;
  logic                  in_range;
  logic                  last_bit;

  assign frame_start = rx_en & fsync & ~fs_q;
  assign in_range    = slot_q < SLOT_LIM;
  assign last_bit    = bit_cnt == LAST_BIT;
  assign slot_done   = rx_en & locked & in_range & ~frame_start & last_bit;
  assign slot_idx    = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      locked  <= 1'b0;
      bit_cnt <= '0;
      slot_q  <= '0;
    end else begin
      fs_q <= fsync;
      if (!rx_en) begin
        locked  <= 1'b0;
        bit_cnt <= '0;
        slot_q  <= '0;
      end else if (frame_start) begin
        locked  <= 1'b1;
        bit_cnt <= BIT_W'(1);
        slot_q  <= '0;
      end else if (locked && in_range) begin
        if (last_bit) begin
          bit_cnt <= '0;
          slot_q  <= slot_q + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (slot_idx == '0));

  assert_slot_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idx <= SLOT_LIM);

  assert_no_done_past_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx == SLOT_LIM) |-> !slot_done);
endmodule

// File: rtl/tdm_shift_capture.sv
module tdm_shift_capture #(
  parameter int SLOT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              sdata,
  output logic [SLOT_W-1:0] word
);
  logic [SLOT_W-2:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (rx_en) begin
      shreg <= {shreg[SLOT_W-3:0], sdata};
    end
  end

  // Word as it stands once the current bit is included (MSB received first).
  assign word = {shreg, sdata};
endmodule

// File: rtl/tdm_out_hold.sv
module tdm_out_hold #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [IDX_W-1:0]  load_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [IDX_W-1:0]  out_slot
);
  logic take;
  logic accept_new;

  assign take       = out_valid & out_ready;
  assign accept_new = load & (~out_valid | out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_slot  <= '0;
    end else if (accept_new) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_slot  <= load_idx;
    end else if (take) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_slot)));

  assert_take_and_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && out_valid && out_ready) |=> (out_valid && out_data == $past(load_data)));
endmodule

// File: rtl/tdm_rx_slot_engine.sv
module tdm_rx_slot_engine
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_W     = 32,
  parameter int MAX_SLOTS  = 384,
  parameter int SLOT_IDX_W = $clog2(MAX_SLOTS + 1)
) (
  input  logic                  bclk,
  input  logic                  rst_n,
  input  logic [1:0]            lane_mode,
  input  logic [31:0]           slot_mask,
  input  logic                  fsync,
  input  logic                  sdata,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SLOT_W-1:0]     out_data,
  output logic [SLOT_IDX_W-1:0] out_slot
);
  localparam int MASK_SEL_W = $clog2(MASK_BITS);

  logic                  rx_en;
  logic                  frame_start;
  logic                  slot_done;
  logic [SLOT_IDX_W-1:0] slot_idx;
  logic [SLOT_W-1:0]     word;
  logic [MASK_SEL_W-1:0] mask_sel;
  logic                  slot_active;
  logic                  capture;

  assign rx_en = (lane_mode_e'(lane_mode) == LANE_RX);

  tdm_slot_tracker #(
    .SLOT_W(SLOT_W), .MAX_SLOTS(MAX_SLOTS), .SLOT_IDX_W(SLOT_IDX_W)
  ) u_tracker (
    .clk(bclk), .rst_n(rst_n), .rx_en(rx_en), .fsync(fsync),
    .frame_start(frame_start), .slot_done(slot_done), .slot_idx(slot_idx)
  );

  tdm_shift_capture #(.SLOT_W(SLOT_W)) u_shift (
    .clk(bclk), .rst_n(rst_n), .rx_en(rx_en), .sdata(sdata), .word(word)
  );

  // Mask bit chosen by slot index modulo the mask width.
  generate
    if (SLOT_IDX_W > MASK_SEL_W) begin : g_wrap_sel
      assign mask_sel = slot_idx[MASK_SEL_W-1:0];
    end else begin : g_pad_sel
      assign mask_sel = MASK_SEL_W'(slot_idx);
    end
  endgenerate

  assign slot_active = slot_mask[mask_sel];
  assign capture     = slot_done & slot_active;

  tdm_out_hold #(.DATA_W(SLOT_W), .IDX_W(SLOT_IDX_W)) u_hold (
    .clk(bclk), .rst_n(rst_n), .load(capture), .load_data(word), .load_idx(slot_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_slot(out_slot)
  );

  assert_rx_mode_only_R1: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(lane_mode) == 2'b10));

  assert_masked_slot_R4: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(out_valid) |-> ((($past(slot_mask) >> (32'(out_slot) % 32)) & 32'd1) != 32'd0));

  assert_index_in_range_R5: assert property (@(posedge bclk) disable iff (!rst_n)
    out_valid |-> (32'(out_slot) < MAX_SLOTS));
endmodule

// File: tb/tdm_rx_slot_engine_bench.sv
`timescale 1ns/1ps
module tdm_rx_slot_engine_bench;
  localparam int SW   = 8;
  localparam int MAXS = 384;
  localparam int IW   = $clog2(MAXS + 1);

  logic          bclk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    lane_mode = 2'b10;
  logic [31:0]   slot_mask = '1;
  logic          fsync = 1'b0;
  logic          sdata = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_data;
  logic [IW-1:0] out_slot;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_req = "R10";

  bit          mv = 0;
  logic [SW-1:0] md = '0;
  int          ms = 0;

  always #10 bclk = ~bclk;

  tdm_rx_slot_engine #(.SLOT_W(SW), .MAX_SLOTS(MAXS)) u_tdm_rx_slot_engine (
    .bclk(bclk), .rst_n(rst_n), .lane_mode(lane_mode), .slot_mask(slot_mask),
    .fsync(fsync), .sdata(sdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_slot(out_slot)
  );

  function automatic logic [SW-1:0] wval(input int fid, input int s);
    return SW'(fid * 53 + s * 29 + 7 + (s >> 3));
  endfunction

  // One bit period: drive at negedge, model the holding register (R8/R9/R11), check next negedge.
  task automatic tick(input logic fs, input logic b, input logic rdy,
                      input bit cap, input logic [SW-1:0] cd, input int cs);
    fsync = fs; sdata = b; out_ready = rdy;
    @(posedge bclk);
    if (cap && (!mv || rdy)) begin mv = 1; md = cd; ms = cs; end
    else if (mv && rdy) mv = 0;
    @(negedge bclk);
    checks++;
    if (out_valid !== mv || (mv && (out_data !== md || int'(out_slot) != ms))) begin
      fails++;
      $display("FAIL %s: valid=%0b data=%0h slot=%0d expected valid=%0b data=%0h slot=%0d",
               cur_req, out_valid, out_data, out_slot, mv, md, ms);
    end
  endtask

  // rdy_at: -1 always ready, -2 never ready, k>=0 ready only on last bit of slot k.
  task automatic run_frame(input int fid, input int nslots, input int tail,
                           input int fs_len, input int rdy_at, input bit live);
    for (int s = 0; s < nslots; s++) begin
      logic [SW-1:0] w;
      w = wval(fid, s);
      for (int b = 0; b < SW; b++) begin
        bit last, cap;
        logic rdy;
        last = (b == SW - 1);
        cap  = live && last && (s < MAXS) && slot_mask[s % 32];
        rdy  = (rdy_at == -1) || (rdy_at >= 0 && last && s == rdy_at);
        tick((s * SW + b) < fs_len, w[SW-1-b], rdy, cap, w, s);
      end
    end
    for (int t = 0; t < tail; t++) tick(1'b0, t[0], 1'b1, 1'b0, '0, 0);
  endtask

  initial begin
    @(negedge bclk); @(negedge bclk);
    cur_req = "R10";
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R10: valid=%0b expected valid=0 in reset", out_valid);
    end
    rst_n = 1'b1;
    // R10: receive mode, bits but no frame start yet
    run_frame(0, 4, 0, 0, -1, 0);

    cur_req = "R11";
    run_frame(1, 1, 0, 1, -1, 1);
    cur_req = "R3";
    for (int n = 2; n <= 5; n++) run_frame(10 + n, n, 0, 1, -1, 1);

    cur_req = "R4";
    foreach (slot_mask[k]) begin end
    for (int m = 0; m < 4; m++) begin
      case (m)
        0: slot_mask = 32'hAAAA_AAAA;
        1: slot_mask = 32'h0000_0001;
        2: slot_mask = 32'h8000_0001;
        default: slot_mask = 32'h0F0F_1234;
      endcase
      run_frame(20 + m, 33, 0, 1, -1, 1);
      run_frame(30 + m, 35, 2, 1, -1, 1);
    end
    slot_mask = '1;

    cur_req = "R6";
    for (int f = 0; f < 3; f++) run_frame(40 + f, 2, 0, SW, -1, 1);

    cur_req = "R2";
    run_frame(45, 3, 0, 2 * SW + 3, -1, 1);

    cur_req = "R7";
    run_frame(50, 3, 5, 1, -1, 1);
    run_frame(51, 2, 0, 1, -1, 1);

    cur_req = "R5";
    run_frame(60, MAXS + 2, 3, 1, -1, 1);

    cur_req = "R1";
    for (int md_i = 0; md_i < 4; md_i++) begin
      if (md_i == 2) continue;
      lane_mode = 2'(md_i);
      run_frame(70 + md_i, 3, 0, 1, -1, 0);
    end
    lane_mode = 2'b10;
    run_frame(75, 2, 0, 1, -1, 1);

    cur_req = "R8";
    run_frame(80, 3, 2, 1, -2, 1);

    cur_req = "R9";
    run_frame(90, 3, 2, 1, 1, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule